// File: doc/BRIEF.md
# Paired-Page Associative Address Translator

This block translates virtual addresses into physical addresses through a small, fully associative table. Each slot covers one aligned virtual region made of two adjacent pages. The lower page of the region is the even half and the upper page is the odd half. Each half has its own physical frame number and its own valid flag. The page size is set separately for every slot, so 4 KB and 16 MB mappings can sit in the table together. A slot's index only says where software loads it. Lookup compares the address against all slots at once and ignores the index.

Software fills a slot with one write: the virtual page number, a size code, the two frame numbers, the two half-valid flags, a global flag and an address space identifier. It can clear one slot or flush the whole table. A separate register holds the current address space identifier. Slots that are not global must match that identifier to take part in a lookup.

A lookup request presents a virtual address. One clock later the block reports exactly one of three results: hit, miss or multiple match. On a hit it also returns the physical address. When more than one slot claims the address, the block reports the overlap and returns no translation. After reset the table is not trusted until software issues a flush. Refilling the table after a miss is left to software.

Top module: `paired_tlb`

## Requirements
- R1: After reset `lk_hit`, `lk_miss`, `lk_multi` and `lk_pa` are low. Every lookup reports a miss until the first `inv_all`, even if slots were written before it.
- R2: A lookup that matches exactly one slot, where the selected half is valid, raises `lk_hit` in the cycle after `lk_req`. `lk_pa` is then the selected frame number shifted left by 12, with the page-offset bits replaced by the same bits of `lk_va`.
- R3: The size code `wr_size` sets the page offset width. The codes and widths are: 0 = 4 KB (12 bits), 1 = 16 KB (14), 2 = 64 KB (16), 3 = 256 KB (18), 4 = 1 MB (20), 5 = 16 MB (24). Codes 6 and 7 act as 16 MB.
- R4: `lk_va` bit number "offset width" selects the half: 0 selects the even half and 1 selects the odd half.
- R5: The tag compare ignores every address bit below "offset width + 1", including those bits of the stored page number. The slot index plays no part in matching.
- R6: A match whose selected half is not valid reports a miss, provided no other slot also matches.
- R7: A slot without the global flag matches only while its identifier equals the current-identifier register, which `asid_we` loads. A slot with the global flag matches under any identifier.
- R8: `inv_en` clears both halves of slot `inv_idx`. If a write targets the same slot in the same cycle, the invalidate wins.
- R9: `inv_all` clears every slot and takes priority over a write in the same cycle.
- R10: If two or more slots match, counting each slot that has at least one valid half, `lk_multi` rises with `lk_hit` and `lk_miss` low and `lk_pa` zero.
- R11: Exactly one of `lk_hit`, `lk_miss` and `lk_multi` is high in the cycle after a request. None of them is high in the cycle after a cycle with no request. `lk_pa` is zero whenever `lk_hit` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| asid_we | input | 1 | Load the current-identifier register |
| asid_wdata | input | ASID_W | New current identifier |
| wr_en | input | 1 | Write one slot |
| wr_idx | input | IDX_W | Slot to write |
| wr_vpn | input | VA_W-12 | Virtual page number (address bits above 12) |
| wr_size | input | 3 | Page size code |
| wr_pfn_even | input | PA_W-12 | Frame number for the even half |
| wr_pfn_odd | input | PA_W-12 | Frame number for the odd half |
| wr_v_even | input | 1 | Even half valid |
| wr_v_odd | input | 1 | Odd half valid |
| wr_global | input | 1 | Match under any identifier |
| wr_asid | input | ASID_W | Identifier of the slot |
| inv_en | input | 1 | Invalidate one slot |
| inv_idx | input | IDX_W | Slot to invalidate |
| inv_all | input | 1 | Flush all slots and mark the table usable |
| lk_req | input | 1 | Lookup request |
| lk_va | input | VA_W | Virtual address to translate |
| lk_hit | output | 1 | Registered hit |
| lk_miss | output | 1 | Registered miss |
| lk_multi | output | 1 | Registered multiple match |
| lk_pa | output | PA_W | Registered physical address |

## Verification
The bench loads a slot for every size code and sweeps addresses across both halves of each region. It checks the last byte of the odd half and the first byte past the region. A design that picked the wrong half-select bit, or that kept the wrong number of offset bits, would return a wrong address or a miss at those edges. The bench then recreates the split-pair case, in which two slots each hold one half of the same region. A design that let one slot win instead of flagging the overlap would show a hit there. It also checks same-cycle conflicts between a write and an invalidate, and between a write and a flush. It checks identifier switching with and without the global flag. It checks stray low bits in the stored page number, which a tag compare that is not masked would turn into a miss.

// File: rtl/paired_tlb_pkg.sv
package paired_tlb_pkg;
  localparam int PG_SHIFT = 12;

  typedef enum logic [2:0] {
    PG_4K   = 3'd0,
    PG_16K  = 3'd1,
    PG_64K  = 3'd2,
    PG_256K = 3'd3,
    PG_1M   = 3'd4,
    PG_16M  = 3'd5
  } pg_size_e;

  // page offset width for a size code; unused codes fold onto the largest page
  function automatic logic [4:0] off_bits(input logic [2:0] code);
    case (code)
      PG_4K:   off_bits = 5'd12;
      PG_16K:  off_bits = 5'd14;
      PG_64K:  off_bits = 5'd16;
      PG_256K: off_bits = 5'd18;
      PG_1M:   off_bits = 5'd20;
      default: off_bits = 5'd24;
    endcase
  endfunction
endpackage

// File: rtl/tlb_array.sv
module tlb_array #(
  parameter int N      = 32,
  parameter int VPN_W  = 20,
  parameter int PFN_W  = 20,
  parameter int ASID_W = 8,
  localparam int IDX_W = $clog2(N)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [VPN_W-1:0]  wr_vpn,
  input  logic [2:0]        wr_size,
  input  logic [PFN_W-1:0]  wr_pfn_even,
  input  logic [PFN_W-1:0]  wr_pfn_odd,
  input  logic              wr_v_even,
  input  logic              wr_v_odd,
  input  logic              wr_global,
  input  logic [ASID_W-1:0] wr_asid,
  input  logic              inv_en,
  input  logic [IDX_W-1:0]  inv_idx,
  input  logic              inv_all,
  output logic [VPN_W-1:0]  e_vpn  [N],
  output logic [2:0]        e_size [N],
  output logic [PFN_W-1:0]  e_pfe  [N],
  output logic [PFN_W-1:0]  e_pfo  [N],
  output logic [N-1:0]      e_ve,
  output logic [N-1:0]      e_vo,
  output logic [N-1:0]      e_glb,
  output logic [ASID_W-1:0] e_asid [N]
);
  // payload fields: written by index, no reset needed
  always_ff @(posedge clk) begin
    if (wr_en) begin
      e_vpn[wr_idx]  <= wr_vpn;
      e_size[wr_idx] <= wr_size;
      e_pfe[wr_idx]  <= wr_pfn_even;
      e_pfo[wr_idx]  <= wr_pfn_odd;
      e_glb[wr_idx]  <= wr_global;
      e_asid[wr_idx] <= wr_asid;
    end
  end

  // half-valid flags: flush beats write, single invalidate beats write
  always_ff @(posedge clk) begin
    if (inv_all) begin
      e_ve <= '0;
      e_vo <= '0;
    end else begin
      if (wr_en) begin
        e_ve[wr_idx] <= wr_v_even;
        e_vo[wr_idx] <= wr_v_odd;
      end
      if (inv_en) begin
        e_ve[inv_idx] <= 1'b0;
        e_vo[inv_idx] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/tlb_match_cell.sv
module tlb_match_cell
  import paired_tlb_pkg::*;
#(
  parameter int VA_W   = 32,
  parameter int PA_W   = 32,
  parameter int ASID_W = 8,
  localparam int VPN_W = VA_W - PG_SHIFT,
  localparam int PFN_W = PA_W - PG_SHIFT
) (
  input  logic [VA_W-1:0]   va,
  input  logic [ASID_W-1:0] cur_asid,
  input  logic [VPN_W-1:0]  vpn,
  input  logic [2:0]        size,
  input  logic [PFN_W-1:0]  pfe,
  input  logic [PFN_W-1:0]  pfo,
  input  logic              ve,
  input  logic              vo,
  input  logic              glb,
  input  logic [ASID_W-1:0] asid,
  output logic              match,
  output logic              sel_ok,
  output logic [PA_W-1:0]   pa
);
  logic [4:0]      off;
  logic [VA_W-1:0] tag_mask;
  logic [PA_W-1:0] off_mask;
  logic [PA_W-1:0] frame;
  logic            odd;
  logic            tag_eq;

  always_comb begin
    off      = off_bits(size);
    tag_mask = ~((VA_W'(1) << (off + 5'd1)) - VA_W'(1));
    off_mask = (PA_W'(1) << off) - PA_W'(1);
    tag_eq   = ((va ^ {vpn, {PG_SHIFT{1'b0}}}) & tag_mask) == '0;
    odd      = va[off];
    match    = tag_eq && (glb || (asid == cur_asid)) && (ve || vo);
    sel_ok   = odd ? vo : ve;
    frame    = {(odd ? pfo : pfe), {PG_SHIFT{1'b0}}};
    pa       = (frame & ~off_mask) | (PA_W'(va) & off_mask);
  end
endmodule

// File: rtl/tlb_resolve.sv
module tlb_resolve #(
  parameter int N    = 32,
  parameter int PA_W = 32,
  localparam int CNT_W = $clog2(N + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req,
  input  logic            armed,
  input  logic [N-1:0]    match,
  input  logic [N-1:0]    sel_ok,
  input  logic [PA_W-1:0] cand_pa [N],
  output logic            hit,
  output logic            miss,
  output logic            multi,
  output logic [PA_W-1:0] pa
);
  logic [CNT_W-1:0] cnt;
  logic [PA_W-1:0]  pa_or;
  logic             one, good;

  always_comb begin
    cnt   = '0;
    pa_or = '0;
    for (int i = 0; i < N; i++) begin
      cnt = cnt + CNT_W'(match[i]);
      if (match[i]) pa_or = pa_or | cand_pa[i];
    end
    one  = (cnt == CNT_W'(1));
    good = |(match & sel_ok);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hit   <= 1'b0;
      miss  <= 1'b0;
      multi <= 1'b0;
      pa    <= '0;
    end else begin
      hit   <= req && armed && one && good;
      multi <= req && armed && (cnt > CNT_W'(1));
      miss  <= req && (!armed || (cnt == '0) || (one && !good));
      pa    <= (req && armed && one && good) ? pa_or : '0;
    end
  end
endmodule

// File: rtl/paired_tlb.sv
module paired_tlb
  import paired_tlb_pkg::*;
#(
  parameter int N      = 32,
  parameter int VA_W   = 32,
  parameter int PA_W   = 32,
  parameter int ASID_W = 8,
  localparam int IDX_W = $clog2(N),
  localparam int VPN_W = VA_W - PG_SHIFT,
  localparam int PFN_W = PA_W - PG_SHIFT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              asid_we,
  input  logic [ASID_W-1:0] asid_wdata,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [VPN_W-1:0]  wr_vpn,
  input  logic [2:0]        wr_size,
  input  logic [PFN_W-1:0]  wr_pfn_even,
  input  logic [PFN_W-1:0]  wr_pfn_odd,
  input  logic              wr_v_even,
  input  logic              wr_v_odd,
  input  logic              wr_global,
  input  logic [ASID_W-1:0] wr_asid,
  input  logic              inv_en,
  input  logic [IDX_W-1:0]  inv_idx,
  input  logic              inv_all,
  input  logic              lk_req,
  input  logic [VA_W-1:0]   lk_va,
  output logic              lk_hit,
  output logic              lk_miss,
  output logic              lk_multi,
  output logic [PA_W-1:0]   lk_pa
);
  logic [ASID_W-1:0] cur_asid;
  logic              armed;

  logic [VPN_W-1:0]  e_vpn  [N];
  logic [2:0]        e_size [N];
  logic [PFN_W-1:0]  e_pfe  [N];
  logic [PFN_W-1:0]  e_pfo  [N];
  logic [N-1:0]      e_ve, e_vo, e_glb;
  logic [ASID_W-1:0] e_asid [N];
  logic [N-1:0]      match, sel_ok;
  logic [PA_W-1:0]   cand_pa [N];

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_asid <= '0;
      armed    <= 1'b0;
    end else begin
      if (asid_we) cur_asid <= asid_wdata;
      if (inv_all) armed <= 1'b1;
    end
  end

  tlb_array #(.N(N), .VPN_W(VPN_W), .PFN_W(PFN_W), .ASID_W(ASID_W)) u_array (
    .clk(clk), .wr_en(wr_en), .wr_idx(wr_idx), .wr_vpn(wr_vpn), .wr_size(wr_size),
    .wr_pfn_even(wr_pfn_even), .wr_pfn_odd(wr_pfn_odd), .wr_v_even(wr_v_even),
    .wr_v_odd(wr_v_odd), .wr_global(wr_global), .wr_asid(wr_asid),
    .inv_en(inv_en), .inv_idx(inv_idx), .inv_all(inv_all),
    .e_vpn(e_vpn), .e_size(e_size), .e_pfe(e_pfe), .e_pfo(e_pfo),
    .e_ve(e_ve), .e_vo(e_vo), .e_glb(e_glb), .e_asid(e_asid)
  );

  for (genvar g = 0; g < N; g++) begin : g_cell
    tlb_match_cell #(.VA_W(VA_W), .PA_W(PA_W), .ASID_W(ASID_W)) u_cell (
      .va(lk_va), .cur_asid(cur_asid), .vpn(e_vpn[g]), .size(e_size[g]),
      .pfe(e_pfe[g]), .pfo(e_pfo[g]), .ve(e_ve[g]), .vo(e_vo[g]),
      .glb(e_glb[g]), .asid(e_asid[g]),
      .match(match[g]), .sel_ok(sel_ok[g]), .pa(cand_pa[g])
    );
  end

  tlb_resolve #(.N(N), .PA_W(PA_W)) u_resolve (
    .clk(clk), .rst(rst), .req(lk_req), .armed(armed),
    .match(match), .sel_ok(sel_ok), .cand_pa(cand_pa),
    .hit(lk_hit), .miss(lk_miss), .multi(lk_multi), .pa(lk_pa)
  );
endmodule

// File: rtl/paired_tlb_chk.sv
module paired_tlb_chk #(
  parameter int PA_W = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            lk_req,
  input logic            inv_all,
  input logic            armed,
  input logic            lk_hit,
  input logic            lk_miss,
  input logic            lk_multi,
  input logic [PA_W-1:0] lk_pa
);
  assert_one_result_R11: assert property (@(posedge clk) disable iff (rst)
    lk_req |=> $onehot({lk_hit, lk_miss, lk_multi}));

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    !lk_req |=> !(lk_hit || lk_miss || lk_multi));

  assert_pa_zero_R11: assert property (@(posedge clk) disable iff (rst)
    !lk_hit |-> lk_pa == '0);

  assert_multi_no_pa_R10: assert property (@(posedge clk) disable iff (rst)
    lk_multi |-> (!lk_hit && lk_pa == '0));

  assert_unarmed_miss_R1: assert property (@(posedge clk) disable iff (rst)
    (lk_req && !armed) |=> lk_miss);

  assert_flush_miss_R9: assert property (@(posedge clk) disable iff (rst)
    ($past(inv_all) && lk_req) |=> lk_miss);
endmodule

bind paired_tlb paired_tlb_chk #(.PA_W(PA_W)) u_chk (
  .clk(clk), .rst(rst), .lk_req(lk_req), .inv_all(inv_all), .armed(armed),
  .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_multi(lk_multi), .lk_pa(lk_pa)
);

// File: tb/paired_tlb_bench.sv
module paired_tlb_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        asid_we = 0;
  logic [7:0]  asid_wdata = 0;
  logic        wr_en = 0;
  logic [4:0]  wr_idx = 0;
  logic [19:0] wr_vpn = 0;
  logic [2:0]  wr_size = 0;
  logic [19:0] wr_pfn_even = 0, wr_pfn_odd = 0;
  logic        wr_v_even = 0, wr_v_odd = 0, wr_global = 0;
  logic [7:0]  wr_asid = 0;
  logic        inv_en = 0;
  logic [4:0]  inv_idx = 0;
  logic        inv_all = 0;
  logic        lk_req = 0;
  logic [31:0] lk_va = 0;
  logic        lk_hit, lk_miss, lk_multi;
  logic [31:0] lk_pa;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  paired_tlb u_paired_tlb (.*);

  function automatic int offw(input int code);
    case (code)
      0: return 12; 1: return 14; 2: return 16; 3: return 18; 4: return 20;
      default: return 24;
    endcase
  endfunction

  function automatic logic [31:0] epa(input logic [19:0] pfn, input int code, input logic [31:0] va);
    logic [31:0] m;
    m = (32'h1 << offw(code)) - 32'h1;
    return ({pfn, 12'h0} & ~m) | (va & m);
  endfunction

  // kind: 0 miss, 1 hit, 2 multi
  task automatic look(input logic [31:0] va, input int kind, input logic [31:0] exp_pa, input string rq);
    @(negedge clk);
    lk_req = 1; lk_va = va;
    @(negedge clk);
    lk_req = 0;
    n_run++;
    if ({lk_hit, lk_miss, lk_multi} != {kind == 1, kind == 0, kind == 2} ||
        lk_pa != ((kind == 1) ? exp_pa : 32'h0)) begin
      n_fail++;
      $display("FAIL %s va=%h got hit/miss/multi=%b pa=%h expected kind=%0d pa=%h",
               rq, va, {lk_hit, lk_miss, lk_multi}, lk_pa, kind, exp_pa);
    end
  endtask

  task automatic wr(input int idx, input logic [31:0] base, input int code, input logic [19:0] pe,
                    input logic [19:0] po, input bit ve, input bit vo, input bit g, input logic [7:0] a);
    @(negedge clk);
    wr_en = 1; wr_idx = idx[4:0]; wr_vpn = base[31:12]; wr_size = code[2:0];
    wr_pfn_even = pe; wr_pfn_odd = po; wr_v_even = ve; wr_v_odd = vo; wr_global = g; wr_asid = a;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic pulse_inv(input bit all, input int idx);
    @(negedge clk);
    inv_all = all; inv_en = !all; inv_idx = idx[4:0];
    @(negedge clk);
    inv_all = 0; inv_en = 0;
  endtask

  task automatic set_asid(input logic [7:0] a);
    @(negedge clk);
    asid_we = 1; asid_wdata = a;
    @(negedge clk);
    asid_we = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R11 watchdog expired: got running, expected finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    n_run++;
    if ({lk_hit, lk_miss, lk_multi} != 3'b000 || lk_pa != 0) begin
      n_fail++;
      $display("FAIL R1 reset outputs got %b/%h expected 000/0", {lk_hit, lk_miss, lk_multi}, lk_pa);
    end

    // R1: written but not flushed -> still miss
    set_asid(8'd5);
    wr(4, 32'h2000_0000, 0, 20'h11111, 20'h22222, 1, 1, 0, 8'd5);
    look(32'h2000_0010, 0, 0, "R1 unflushed");
    pulse_inv(1, 0);
    look(32'h2000_0010, 0, 0, "R9 flush cleared slot");

    // R2/R3/R4 sweep over all size codes, slots spread across the index space
    for (int code = 0; code < 8; code++) begin
      logic [31:0] base;
      logic [19:0] pe, po;
      int o;
      base = (code + 1) << 25;
      pe = 20'hA1234 ^ 20'(code);
      po = 20'h5ABCD + 20'(code);
      o = offw(code);
      wr(code * 3 + 1, base, code, pe, po, 1, 1, 0, 8'd5);
      for (int k = 0; k < 8; k++) begin
        logic [31:0] va;
        va = base + k * ((32'h1 << o) / 4) + k;
        look(va, 1, epa(va[o] ? po : pe, code, va), "R2 R3 R4 sweep");
      end
      look(base + (32'h2 << o) - 1, 1, epa(po, code, base + (32'h2 << o) - 1), "R4 last odd byte");
      if (code < 5) look(base + (32'h2 << o), 0, 0, "R3 past region");
    end

    // R6: even half only
    wr(30, 32'h3000_0000, 0, 20'h0AAAA, 20'h0BBBB, 1, 0, 0, 8'd5);
    look(32'h3000_0123, 1, epa(20'h0AAAA, 0, 32'h3000_0123), "R6 valid even half");
    look(32'h3000_1123, 0, 0, "R6 invalid odd half");

    // R7: identifier handling
    wr(29, 32'h3100_0000, 0, 20'h0CCCC, 20'h0DDDD, 1, 1, 1, 8'd9);
    set_asid(8'd6);
    look(32'h0200_0040, 0, 0, "R7 foreign identifier");
    look(32'h3100_1008, 1, epa(20'h0DDDD, 0, 32'h3100_1008), "R7 global slot");
    set_asid(8'd5);
    look(32'h0200_0040, 1, epa(20'hA1234, 0, 32'h0200_0040), "R7 identifier restored");

    // R10: split pair across two slots
    wr(0, 32'h3200_0000, 0, 20'h0E000, 20'h0, 1, 0, 0, 8'd5);
    wr(31, 32'h3200_0000, 0, 20'h0, 20'h0F000, 0, 1, 0, 8'd5);
    look(32'h3200_0004, 2, 0, "R10 overlap even");
    look(32'h3200_1004, 2, 0, "R10 overlap odd");
    pulse_inv(0, 31);
    look(32'h3200_0004, 1, epa(20'h0E000, 0, 32'h3200_0004), "R8 overlap removed");
    look(32'h3200_1004, 0, 0, "R8 R6 odd gone");

    // R8: single invalidate, and same-cycle write+invalidate
    pulse_inv(0, 1);
    look(32'h0200_0040, 0, 0, "R8 slot cleared even");
    look(32'h0200_1040, 0, 0, "R8 slot cleared odd");
    @(negedge clk);
    wr_en = 1; wr_idx = 5'd2; wr_vpn = 20'h33000; wr_size = 3'd0;
    wr_pfn_even = 20'h1; wr_pfn_odd = 20'h2; wr_v_even = 1; wr_v_odd = 1; wr_global = 1;
    inv_en = 1; inv_idx = 5'd2;
    @(negedge clk);
    wr_en = 0; inv_en = 0;
    look(32'h3300_0000, 0, 0, "R8 invalidate beats write");

    // R5: stray low bits in stored page number and a 64 KB page
    @(negedge clk);
    wr_en = 1; wr_idx = 5'd17; wr_vpn = 20'h3501F; wr_size = 3'd2;
    wr_pfn_even = 20'h40000; wr_pfn_odd = 20'h50000; wr_v_even = 1; wr_v_odd = 1;
    wr_global = 0; wr_asid = 8'd5;
    @(negedge clk);
    wr_en = 0;
    look(32'h3500_0010, 1, epa(20'h40000, 2, 32'h3500_0010), "R5 masked low tag bits");
    look(32'h3501_ABCD, 1, epa(20'h50000, 2, 32'h3501_ABCD), "R5 odd half");

    // R9: flush beats same-cycle write
    @(negedge clk);
    wr_en = 1; wr_idx = 5'd3; wr_vpn = 20'h34000; wr_size = 3'd0;
    wr_pfn_even = 20'h7; wr_pfn_odd = 20'h8; wr_v_even = 1; wr_v_odd = 1; wr_global = 1;
    inv_all = 1;
    @(negedge clk);
    wr_en = 0; inv_all = 0;
    look(32'h3400_0000, 0, 0, "R9 flush beats write");
    look(32'h3500_0010, 0, 0, "R9 flush cleared all");
    look(32'h0400_0000, 0, 0, "R9 flush cleared sweep slot");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule